// File: doc/BRIEF.md
# Stream Channel with End Marker and Overflow Status

This block is a single point-to-point stream channel: one producing process writes words on one side, one consuming process reads them on the other. Words wait in a ring buffer whose depth is fixed at elaboration, and a consumer that asks for a word while nothing is queued stalls until one arrives. The producer can close the stream. Closing places an end marker in the queue behind everything already written. A consumer that reads the marker receives zero and from then on sees the stream as ended.

The marker travels as one tag bit stored beside each data word, so every data value, zero included, stays a legal payload. A write offered while the queue is full is not stalled. The word is dropped and a sticky overflow code is recorded, and the code clears once the consumer reads it. Either side can open the channel, which returns all channel state to empty without raising an error. Both data paths use valid/ready handshakes. When the queue is full, a read and a write in the same cycle are both taken.

Top module: `stream_chan`

## Requirements
- R1: `DEPTH` may be 16, 32 or 64 and defaults to 16. After exactly `DEPTH` accepted elements with no read, `level` equals `DEPTH` and `wr_ready` is 0. With fewer elements queued, `wr_ready` is 1.
- R2: Data words leave on `rd_data` in the order they were accepted, with values unchanged, and the value zero is passed as ordinary data. A transfer happens in a cycle where `rd_valid` and `rd_ready` are both 1.
- R3: A write offered while `wr_ready` is 0 is dropped and `level` does not change. From the next cycle `err_code` reads 1, which means overflow.
- R4: `err_code` reads 0 when there is no error. In a cycle with `err_rd` high, `err_code` still shows the current code, and it reads 0 from the next cycle unless a new overflow happens in that same cycle.
- R5: A pulse on `wr_close` enqueues one end marker behind all earlier data. If `wr_valid` is high in the same cycle, the close wins and that data word is not enqueued.
- R6: When the marker is not at the head and the end flag is clear, `rd_eos` is 0. `rd_eos` is 1 while the head element is the marker, and in that state `rd_data` shows 0.
- R7: Reading the marker returns 0 and sets a sticky end flag. From then on `rd_eos` is 1, `rd_valid` is 1 and every read returns 0 without removing anything from the queue.
- R8: While the queue is empty and the end flag is clear, `rd_valid` is 0, so the consumer stalls.
- R9: A pulse on `wr_open` or `rd_open` empties the queue and clears the end flag and the error code from the next cycle. A transfer offered in that cycle is ignored, and opening raises no error.
- R10: A read and a write in the same cycle on a full queue are both accepted. `level` stays at `DEPTH` and no overflow is recorded.
- R11: After reset the queue is empty: `level` is 0, `rd_valid`, `rd_eos` and `err_code` are 0, and `wr_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_open | input | 1 | Producer-side open pulse; clears the channel |
| wr_valid | input | 1 | Producer offers a data word |
| wr_data | input | DATA_W | Data word offered by the producer |
| wr_close | input | 1 | Producer close pulse; enqueues the end marker |
| wr_ready | output | 1 | Channel accepts a write in this cycle |
| rd_open | input | 1 | Consumer-side open pulse; clears the channel |
| rd_ready | input | 1 | Consumer requests a read |
| rd_valid | output | 1 | A read can complete in this cycle |
| rd_data | output | DATA_W | Head data word, or zero for the marker or an ended stream |
| rd_eos | output | 1 | End-of-stream query result |
| err_rd | input | 1 | Read-and-clear strobe for the error code |
| err_code | output | 2 | Error code: 0 none, 1 overflow |
| level | output | $clog2(DEPTH)+1 | Number of queued elements, marker included |

## Verification
The bench builds the main instance with the default depth of 16 and a word width of 16 bits. This keeps a full queue, an overflow, a same-cycle read and write at the full boundary, and a complete drain within a few dozen cycles each. A second instance is built with a depth of 32 and is only filled. It shows that `wr_ready` stays high past sixteen elements and drops at exactly thirty-two, so the full boundary is shown to follow the parameter.

// File: rtl/chan_pkg.sv
package chan_pkg;

  localparam int ERR_W = 2;

  typedef enum logic [ERR_W-1:0] {
    ERR_NONE     = 2'd0,
    ERR_OVERFLOW = 2'd1
  } err_e;

  // Occupancy after one cycle of push/pop; the clear input wins.
  function automatic int unsigned lvl_step(int unsigned cur, logic clr,
                                           logic push, logic pop);
    if (clr) return 0;
    if (push && !pop) return cur + 1;
    if (pop && !push) return cur - 1;
    return cur;
  endfunction

endpackage

// File: rtl/chan_ring.sv
module chan_ring #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = AW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              push,
  input  logic              push_tag,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic              head_tag,
  output logic [DATA_W-1:0] head_data,
  output logic [LW-1:0]     level,
  output logic              empty,
  output logic              full
);
  import chan_pkg::*;

  // Each slot holds the end-marker tag above the data word.
  logic [DATA_W:0] slots [DEPTH];
  logic [AW-1:0]   wp, rp;

  always_ff @(posedge clk) begin
    if (push && !clear) slots[wp] <= {push_tag, push_data};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (clear) begin
        wp <= '0;
        rp <= '0;
      end else begin
        if (push) wp <= wp + 1'b1;
        if (pop)  rp <= rp + 1'b1;
      end
      level <= LW'(lvl_step(int'(level), clear, push, pop));
    end
  end

  assign head_tag  = slots[rp][DATA_W];
  assign head_data = slots[rp][DATA_W-1:0];
  assign empty     = (level == '0);
  assign full      = (level == LW'(DEPTH));

endmodule

// File: rtl/chan_flags.sv
module chan_flags
  import chan_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             eos_hit,
  input  logic             ovf_evt,
  input  logic             err_rd,
  output logic             eos_flag,
  output logic [ERR_W-1:0] err_code
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eos_flag <= 1'b0;
      err_code <= ERR_NONE;
    end else if (clear) begin
      eos_flag <= 1'b0;
      err_code <= ERR_NONE;
    end else begin
      if (eos_hit) eos_flag <= 1'b1;
      // A fresh overflow wins over a same-cycle clear-on-read.
      if (ovf_evt)     err_code <= ERR_OVERFLOW;
      else if (err_rd) err_code <= ERR_NONE;
    end
  end

endmodule

// File: rtl/stream_chan.sv
module stream_chan
  import chan_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_open,
  input  logic              wr_valid,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_close,
  output logic              wr_ready,
  input  logic              rd_open,
  input  logic              rd_ready,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_eos,
  input  logic              err_rd,
  output logic [ERR_W-1:0]  err_code,
  output logic [LW-1:0]     level
);

  // Named internal events, also observed by the bound checker.
  logic any_open, wr_try, push, pop, ovf_evt, eos_hit;
  logic head_tag, empty, full, eos_flag, can_pop;
  logic [DATA_W-1:0] head_data, push_data;

  assign any_open = wr_open | rd_open;
  assign wr_try   = wr_valid | wr_close;

  // A real element leaves only while the stream has not ended.
  assign can_pop  = rd_ready & ~empty & ~eos_flag;
  assign wr_ready = ~full | can_pop;

  assign pop      = can_pop & ~any_open;
  assign push     = wr_try & wr_ready & ~any_open;
  assign ovf_evt  = wr_try & ~wr_ready & ~any_open;
  assign eos_hit  = pop & head_tag;

  // Close has priority: the marker carries a zero payload.
  assign push_data = wr_close ? '0 : wr_data;

  assign rd_valid = ~empty | eos_flag;
  assign rd_data  = (eos_flag | empty | head_tag) ? '0 : head_data;
  assign rd_eos   = eos_flag | (~empty & head_tag);

  chan_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (any_open),
    .push      (push),
    .push_tag  (wr_close),
    .push_data (push_data),
    .pop       (pop),
    .head_tag  (head_tag),
    .head_data (head_data),
    .level     (level),
    .empty     (empty),
    .full      (full)
  );

  chan_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (any_open),
    .eos_hit  (eos_hit),
    .ovf_evt  (ovf_evt),
    .err_rd   (err_rd),
    .eos_flag (eos_flag),
    .err_code (err_code)
  );

endmodule

// File: rtl/chan_chk.sv
module chan_chk #(
  parameter int DATA_W = 16,
  parameter int DEPTH  = 16,
  localparam int LW = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              any_open,
  input logic              err_rd,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_eos,
  input logic [1:0]        err_code,
  input logic [LW-1:0]     level,
  input logic              push,
  input logic              pop,
  input logic              ovf_evt,
  input logic              eos_hit
);

  a_r1_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= LW'(DEPTH));

  a_r3_drop_flags_error: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> (err_code == 2'd1));

  a_r3_drop_keeps_level: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_evt && !pop) |=> $stable(level));

  a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (err_rd && !ovf_evt && !any_open) |=> (err_code == 2'd0));

  a_r7_end_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    eos_hit |=> (rd_eos && rd_valid && rd_data == '0));

  a_r8_empty_stalls: assert property (@(posedge clk) disable iff (!rst_n)
    (level == '0 && !rd_eos) |-> !rd_valid);

  a_r9_open_clears: assert property (@(posedge clk) disable iff (!rst_n)
    any_open |=> (level == '0 && !rd_eos && err_code == 2'd0));

  a_r10_both_keep_level: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> $stable(level));

endmodule

bind stream_chan chan_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .any_open (any_open),
  .err_rd   (err_rd),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .rd_eos   (rd_eos),
  .err_code (err_code),
  .level    (level),
  .push     (push),
  .pop      (pop),
  .ovf_evt  (ovf_evt),
  .eos_hit  (eos_hit)
);

// File: tb/sim_stream_chan.sv
module sim_stream_chan;
  localparam int DW = 16;
  localparam int DP = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic wr_open = 0, wr_valid = 0, wr_close = 0, rd_open = 0, rd_ready = 0, err_rd = 0;
  logic [DW-1:0] wr_data = '0;
  logic wr_ready, rd_valid, rd_eos;
  logic [DW-1:0] rd_data;
  logic [1:0] err_code;
  logic [$clog2(DP):0] level;

  stream_chan #(.DATA_W(DW), .DEPTH(DP)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_open(wr_open), .wr_valid(wr_valid),
    .wr_data(wr_data), .wr_close(wr_close), .wr_ready(wr_ready),
    .rd_open(rd_open), .rd_ready(rd_ready), .rd_valid(rd_valid),
    .rd_data(rd_data), .rd_eos(rd_eos), .err_rd(err_rd),
    .err_code(err_code), .level(level));

  // Second build with depth 32, only filled.
  logic w1_valid = 0;
  logic [DW-1:0] w1_data = '0;
  logic w1_ready, r1_valid, r1_eos;
  logic [DW-1:0] r1_data;
  logic [1:0] e1_code;
  logic [5:0] l1;

  stream_chan #(.DATA_W(DW), .DEPTH(32)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_open(1'b0), .wr_valid(w1_valid),
    .wr_data(w1_data), .wr_close(1'b0), .wr_ready(w1_ready),
    .rd_open(1'b0), .rd_ready(1'b0), .rd_valid(r1_valid),
    .rd_data(r1_data), .rd_eos(r1_eos), .err_rd(1'b0),
    .err_code(e1_code), .level(l1));

  int n_chk = 0;
  int n_bad = 0;
  logic [DW:0] exp_q[$];

  task automatic chk(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Driver: predicts acceptance from the requirements and feeds the scoreboard.
  task automatic step(bit wv, logic [DW-1:0] wd, bit wc, bit rr, bit er, bit wo, bit ro);
    int n;
    bit pop_p, acc;
    @(posedge clk); #2;
    n     = exp_q.size();
    pop_p = rr && n > 0 && !(wo || ro);
    acc   = (wv || wc) && !(wo || ro) && (n < DP || pop_p);
    if (wo || ro) exp_q.delete();
    else if (acc) exp_q.push_back(wc ? {1'b1, {DW{1'b0}}} : {1'b0, wd});
    wr_valid = wv; wr_data = wd; wr_close = wc; rd_ready = rr;
    err_rd = er; wr_open = wo; rd_open = ro;
  endtask

  task automatic settle();
    step(0, '0, 0, 0, 0, 0, 0);
    @(negedge clk);
  endtask

  // Monitor: every completed read is compared with the scoreboard head (R2, R7).
  always @(negedge clk) begin : mon
    logic [DW:0] e;
    if (rst_n && rd_valid && rd_ready && !wr_open && !rd_open) begin
      if (exp_q.size() == 0) chk("R7 read after end", int'(rd_data), 0);
      else begin
        e = exp_q.pop_front();
        chk("R2 read order/value", int'(rd_data), e[DW] ? 0 : int'(e[DW-1:0]));
      end
    end
  end

  initial begin : watchdog
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    chk("R11 level", int'(level), 0);
    chk("R11 rd_valid", int'(rd_valid), 0);
    chk("R11 rd_eos", int'(rd_eos), 0);
    chk("R11 err_code", int'(err_code), 0);
    chk("R11 wr_ready", int'(wr_ready), 1);

    // R2 / R6: zero is plain data.
    for (int i = 0; i < 5; i++) step(1, (i == 0) ? 16'h0 : 16'(16'h1000 + i * 37), 0, 0, 0, 0, 0);
    settle();
    chk("R2 level after writes", int'(level), 5);
    chk("R6 zero data head not end", int'(rd_eos), 0);
    for (int i = 0; i < 5; i++) step(0, '0, 0, 1, 0, 0, 0);
    step(0, '0, 0, 1, 0, 0, 0);
    @(negedge clk);
    chk("R8 empty stalls", int'(rd_valid), 0);
    chk("R8 level", int'(level), 0);

    // R1 / R3
    for (int i = 0; i < DP; i++) step(1, 16'(16'h2000 + i), 0, 0, 0, 0, 0);
    settle();
    chk("R1 level full", int'(level), DP);
    chk("R1 wr_ready low", int'(wr_ready), 0);
    step(1, 16'hDEAD, 0, 0, 0, 0, 0);
    settle();
    chk("R3 err overflow", int'(err_code), 1);
    chk("R3 level unchanged", int'(level), DP);

    // R4
    step(0, '0, 0, 0, 1, 0, 0);
    @(negedge clk);
    chk("R4 code visible on read", int'(err_code), 1);
    settle();
    chk("R4 code cleared", int'(err_code), 0);

    // R10
    step(1, 16'h7777, 0, 1, 0, 0, 0);
    @(negedge clk);
    chk("R10 wr_ready with read", int'(wr_ready), 1);
    settle();
    chk("R10 level stays full", int'(level), DP);
    chk("R10 no overflow", int'(err_code), 0);
    for (int i = 0; i < DP; i++) step(0, '0, 0, 1, 0, 0, 0);
    settle();
    chk("R2 drained", int'(level), 0);

    // R5 / R6 / R7
    step(1, 16'h0055, 0, 0, 0, 0, 0);
    step(1, 16'h00AA, 0, 0, 0, 0, 0);
    step(1, 16'hBEEF, 1, 0, 0, 0, 0);
    settle();
    chk("R5 marker only on close", int'(level), 3);
    chk("R6 data head", int'(rd_eos), 0);
    step(0, '0, 0, 1, 0, 0, 0);
    step(0, '0, 0, 1, 0, 0, 0);
    settle();
    chk("R6 marker head eos", int'(rd_eos), 1);
    chk("R6 marker head data", int'(rd_data), 0);
    chk("R5 marker last", int'(level), 1);
    step(0, '0, 0, 1, 0, 0, 0);
    settle();
    chk("R7 eos sticky", int'(rd_eos), 1);
    chk("R7 rd_valid", int'(rd_valid), 1);
    chk("R7 rd_data zero", int'(rd_data), 0);
    chk("R7 level", int'(level), 0);
    step(0, '0, 0, 1, 0, 0, 0);
    settle();
    chk("R7 level after extra read", int'(level), 0);

    // R9
    step(0, '0, 0, 0, 0, 0, 1);
    settle();
    chk("R9 eos cleared", int'(rd_eos), 0);
    chk("R9 rd_valid", int'(rd_valid), 0);
    for (int i = 0; i < DP + 1; i++) step(1, 16'(i), 0, 0, 0, 0, 0);
    settle();
    chk("R3 second overflow", int'(err_code), 1);
    step(1, 16'h1234, 0, 0, 0, 1, 0);
    settle();
    chk("R9 level cleared", int'(level), 0);
    chk("R9 err cleared", int'(err_code), 0);
    chk("R9 wr_ready", int'(wr_ready), 1);

    // R1 on the depth-32 build
    for (int i = 0; i < 32; i++) begin
      @(posedge clk); #2;
      w1_valid = 1'b1; w1_data = 16'(i);
      if (i == 16) begin
        @(negedge clk);
        chk("R1 depth32 ready past 16", int'(w1_ready), 1);
      end
    end
    @(posedge clk); #2 w1_valid = 1'b0;
    @(negedge clk);
    chk("R1 depth32 level", int'(l1), 32);
    chk("R1 depth32 ready low", int'(w1_ready), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule